// File: doc/BRIEF.md
# Chainable Event Counter Bank

The block is a bank of 32-bit event counters and one 64-bit cycle counter. Software programs it through a synchronous register write port and a combinational read port. Each event counter has its own event-type register. The type names the index of a per-cycle event pulse input to count. It can also select one of two special behaviours: counting software-increment writes, or acting as the upper half of a 64-bit chained count.

Counters form even/odd pairs. The pair fuses into a 64-bit counter when the odd member selects the chain type and is actively enabled. The even member then holds the low word and the odd member the high word. Overflow flags are sticky and software clears them. An interrupt level is raised while any flag is both counter-enabled and interrupt-enabled under the global enable. Control-register bits clear all event counters or the cycle counter. A count field in the same register limits which event counters exist.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every readable register, including every counter, reads zero and `irq` is low.
- R2: An implemented event counter counts by one in each cycle in which the pulse input indexed by its event type is high. It does so only while global enable (control bit 0) and its own enable bit are both set, and otherwise holds its value.
- R3: The pair (2k, 2k+1) is chained while counter 2k+1 has event type 0x1E and is enabled under global enable. A wrap of counter 2k then increments counter 2k+1 instead of flagging bit 2k, and only a wrap of counter 2k+1 sets flag bit 2k+1. A software-increment bit aimed at the chained odd counter does nothing.
- R4: A wrap from 0xFFFFFFFF of a counter that is not the low half of a chained pair sets its overflow flag bit.
- R5: A write to address 0x06 increments each counter whose bit is set in the data, whose enable bit is set, and whose event type is 0x00. The write is ignored when global enable is clear, and bit 31 never moves the cycle counter.
- R6: The cycle counter (enable, flag and interrupt bit 31; low word at 0x07, high word at 0x08) counts every clock while enabled. It sets flag bit 31 when its low 32 bits wrap if control bit 6 is clear, and only when all 64 bits wrap if bit 6 is set.
- R7: `irq` is high exactly when global enable is set and (overflow flags AND counter enables AND interrupt enables) is nonzero.
- R8: Counter enables are set by writing ones to 0x01 and cleared by writing ones to 0x02, and both addresses read the enables. Interrupt enables use 0x03 and 0x04 in the same way. Flags read at 0x05 and are cleared by writing ones there.
- R9: Writing control (0x00) with bit 2 set clears the cycle counter. Writing it with bit 1 set clears every implemented event counter and leaves the cycle counter untouched.
- R10: Control bits 15:11 give N: counters 0..N-1 exist, together with the cycle counter. Other event counters (value at 0x10+i, type at 0x20+i) read zero, ignore writes and enable sets, and do not count. With N=0 only the cycle counter works.
- R11: An event-type write keeps only the low 16 bits (10 bits when the narrow variant is chosen), and the dropped bits read back as zero.
- R12: Entering or leaving the chained state leaves both counter values unchanged and sets no overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| evt_in | input | NUM_EVT | Per-cycle event pulses, indexed by event number |
| irq | output | 1 | Overflow interrupt level |

## Verification
Writes and event pulses that are present before a rising edge show in the counters and flags right after that edge. Reads are combinational, so a value is due in the same cycle its address is presented. `irq` is derived directly from the registered flags and enables, so it follows in the same cycle as the flag change it reflects. The bench changes inputs on the falling edge and steps a behavioural model on the rising edge. It compares every read and `irq` one time unit after a falling edge, when both the model and the design have taken the same edge.

// File: rtl/ecb_pkg.sv
// Package: shared constants for the chainable event counter bank.
// Assumes a 6-bit register address space and at most 16 event counters.
package ecb_pkg;
    localparam int          ADDR_W     = 6;
    localparam int          CYC_IDX    = 31;
    localparam logic [15:0] SW_EVT     = 16'h0000;
    localparam logic [15:0] CHAIN_EVT  = 16'h001E;

    localparam logic [ADDR_W-1:0] A_CTRL    = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET  = 6'h01;
    localparam logic [ADDR_W-1:0] A_EN_CLR  = 6'h02;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 6'h03;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 6'h04;
    localparam logic [ADDR_W-1:0] A_OVF     = 6'h05;
    localparam logic [ADDR_W-1:0] A_SWINC   = 6'h06;
    localparam logic [ADDR_W-1:0] A_CYC_LO  = 6'h07;
    localparam logic [ADDR_W-1:0] A_CYC_HI  = 6'h08;
    localparam int                A_CNT0    = 16;
    localparam int                A_TYP0    = 32;

    localparam int CB_ENABLE = 0;
    localparam int CB_PCLR   = 1;
    localparam int CB_CCLR   = 2;
    localparam int CB_LONG   = 6;
    localparam int CB_N_LO   = 11;
    localparam int CB_N_HI   = 15;
endpackage

// File: rtl/ecb_pair.sv
// Module: one even/odd pair of 32-bit event counters.
// Does: counts selected event pulses or software increments per half and
// chains the halves into one 64-bit count when the odd half selects the
// chain type and is active. Assumes the caller has already folded global
// enable, per-counter enable and the implemented range into act.
module ecb_pair
    import ecb_pkg::*;
#(
    parameter int EVT_W   = 16,
    parameter int NUM_EVT = 32
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         act,
    input  logic [EVT_W-1:0]   type_lo,
    input  logic [EVT_W-1:0]   type_hi,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [1:0]         sw_hit,
    input  logic [1:0]         load,
    input  logic [31:0]        load_val,
    input  logic [1:0]         clr,
    output logic [31:0]        cnt_lo,
    output logic [31:0]        cnt_hi,
    output logic [1:0]         ovf_set
);
    logic chained;
    logic lo_inc, lo_wrap, hi_inc, hi_wrap;

    // Picks the single-cycle increment source that an event type selects.
    function automatic logic pick_src(input logic [EVT_W-1:0] t,
                                      input logic [NUM_EVT-1:0] ev,
                                      input logic sw);
        logic r;
        r = 1'b0;
        if (t == EVT_W'(SW_EVT)) begin
            r = sw;
        end else if (t != EVT_W'(CHAIN_EVT)) begin
            for (int k = 0; k < NUM_EVT; k++) begin
                if (int'(t) == k) r = ev[k];
            end
        end
        return r;
    endfunction

    // Decides the chain state and both halves' increments for this cycle.
    always_comb begin
        chained = act[1] && (type_hi == EVT_W'(CHAIN_EVT));
        lo_inc  = act[0] && !load[0] && !clr[0] && pick_src(type_lo, evt_in, sw_hit[0]);
        lo_wrap = lo_inc && (&cnt_lo);
        hi_inc  = act[1] && !load[1] && !clr[1] &&
                  (chained ? lo_wrap : pick_src(type_hi, evt_in, sw_hit[1]));
        hi_wrap = hi_inc && (&cnt_hi);
        ovf_set = {hi_wrap, lo_wrap && !chained};
    end

    // Low half storage: clear, load or count.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_lo <= '0;
        else if (clr[0])  cnt_lo <= '0;
        else if (load[0]) cnt_lo <= load_val;
        else if (lo_inc)  cnt_lo <= cnt_lo + 32'd1;
    end

    // High half storage: clear, load or count (own event or carry).
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_hi <= '0;
        else if (clr[1])  cnt_hi <= '0;
        else if (load[1]) cnt_hi <= load_val;
        else if (hi_inc)  cnt_hi <= cnt_hi + 32'd1;
    end

    // R2: an unloaded low half moves by at most one per cycle.
    p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load[0] && !clr[0]) |=> (cnt_lo == $past(cnt_lo) || cnt_lo == $past(cnt_lo) + 32'd1));

    // R3: in a chained pair the high half only steps together with a low wrap.
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && !load[1] && !clr[1]) |=>
        (cnt_hi == $past(cnt_hi) || (cnt_lo == 32'd0 && cnt_hi == $past(cnt_hi) + 32'd1)));
endmodule

// File: rtl/ecb_cycle.sv
// Module: the 64-bit cycle counter.
// Does: counts every clock while active and flags overflow either at the
// 32-bit or the 64-bit boundary. Assumes at most one of clr/load per cycle
// wins in the order clr, load low, load high.
module ecb_cycle (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        act,
    input  logic        long_mode,
    input  logic        clr,
    input  logic        load_lo,
    input  logic        load_hi,
    input  logic [31:0] load_val,
    output logic [63:0] cnt,
    output logic        ovf_set
);
    logic step;

    // Works out whether the counter steps and whether that step wraps.
    always_comb begin
        step    = act && !clr && !load_lo && !load_hi;
        ovf_set = step && (long_mode ? (&cnt) : (&cnt[31:0]));
    end

    // Counter storage with clear and per-word load.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (load_lo) cnt <= {cnt[63:32], load_val};
        else if (load_hi) cnt <= {load_val, cnt[31:0]};
        else if (step)    cnt <= cnt + 64'd1;
    end

    // R6: an active, undisturbed cycle counter advances by exactly one.
    p_cyc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !clr && !load_lo && !load_hi) |=> (cnt == $past(cnt) + 64'd1));

    // R6: an inactive, undisturbed cycle counter holds.
    p_cyc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !clr && !load_lo && !load_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_counter_bank.sv
// Module: top of the chainable event counter bank.
// Does: holds control, enable, interrupt-enable, overflow and event-type
// registers, decodes the register port, and instantiates the counter pairs
// and the cycle counter. Assumes NUM_CTR is even and no larger than 16.
module evt_counter_bank
    import ecb_pkg::*;
#(
    parameter int NUM_CTR  = 6,
    parameter int NUM_EVT  = 32,
    parameter bit WIDE_EVT = 1'b1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [5:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [5:0]         rd_addr,
    output logic [31:0]        rd_data,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int EVT_W    = WIDE_EVT ? 16 : 10;
    localparam int NUM_PAIR = NUM_CTR / 2;

    logic               ctl_en, ctl_long;
    logic [4:0]         ctl_n;
    logic [31:0]        cnt_en, int_en, ovf_flag;
    logic [EVT_W-1:0]   evt_type [NUM_CTR];
    logic [31:0]        cnt_val  [NUM_CTR];
    logic [63:0]        cyc_cnt;
    logic               cyc_ovf;
    logic [NUM_CTR-1:0] ev_ovf;

    logic [31:0]        impl_mask, ovf_set_all, w1c_bits, ovf_keep;
    logic [NUM_CTR-1:0] act_vec, sw_vec, cnt_ld, clr_vec;
    logic               wr_ctrl, p_clr, c_clr;

    // Decodes writes and builds the per-counter control vectors.
    always_comb begin
        impl_mask = '0;
        for (int i = 0; i < NUM_CTR; i++) impl_mask[i] = (i < int'(ctl_n));
        impl_mask[CYC_IDX] = 1'b1;
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        p_clr    = wr_ctrl && wr_data[CB_PCLR];
        c_clr    = wr_ctrl && wr_data[CB_CCLR];
        w1c_bits = (wr_en && wr_addr == A_OVF) ? wr_data : '0;
        ovf_keep = ovf_flag & ~w1c_bits;
        for (int i = 0; i < NUM_CTR; i++) begin
            act_vec[i] = ctl_en && cnt_en[i] && impl_mask[i];
            sw_vec[i]  = wr_en && (wr_addr == A_SWINC) && ctl_en && wr_data[i];
            cnt_ld[i]  = wr_en && (wr_addr == ADDR_W'(A_CNT0 + i)) && impl_mask[i];
            clr_vec[i] = p_clr && impl_mask[i];
        end
    end

    for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
        ecb_pair #(.EVT_W(EVT_W), .NUM_EVT(NUM_EVT)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .act      (act_vec[2*g+1:2*g]),
            .type_lo  (evt_type[2*g]),
            .type_hi  (evt_type[2*g+1]),
            .evt_in   (evt_in),
            .sw_hit   (sw_vec[2*g+1:2*g]),
            .load     (cnt_ld[2*g+1:2*g]),
            .load_val (wr_data),
            .clr      (clr_vec[2*g+1:2*g]),
            .cnt_lo   (cnt_val[2*g]),
            .cnt_hi   (cnt_val[2*g+1]),
            .ovf_set  (ev_ovf[2*g+1:2*g])
        );
    end

    ecb_cycle u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (ctl_en && cnt_en[CYC_IDX]),
        .long_mode (ctl_long),
        .clr       (c_clr),
        .load_lo   (wr_en && wr_addr == A_CYC_LO),
        .load_hi   (wr_en && wr_addr == A_CYC_HI),
        .load_val  (wr_data),
        .cnt       (cyc_cnt),
        .ovf_set   (cyc_ovf)
    );

    // Gathers the overflow events of this cycle into flag positions.
    always_comb begin
        ovf_set_all = '0;
        ovf_set_all[NUM_CTR-1:0] = ev_ovf;
        ovf_set_all[CYC_IDX] = cyc_ovf;
    end

    // Control register: global enable, long cycle mode, implemented count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en   <= 1'b0;
            ctl_long <= 1'b0;
            ctl_n    <= '0;
        end else if (wr_ctrl) begin
            ctl_en   <= wr_data[CB_ENABLE];
            ctl_long <= wr_data[CB_LONG];
            ctl_n    <= wr_data[CB_N_HI:CB_N_LO];
        end
    end

    // Counter and interrupt enables with separate set and clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en <= '0;
            int_en <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EN_SET) cnt_en <= cnt_en | (wr_data & impl_mask);
            if (wr_addr == A_EN_CLR) cnt_en <= cnt_en & ~(wr_data & impl_mask);
            if (wr_addr == A_IE_SET) int_en <= int_en | (wr_data & impl_mask);
            if (wr_addr == A_IE_CLR) int_en <= int_en & ~(wr_data & impl_mask);
        end
    end

    // Sticky overflow flags: hardware sets, write-one clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= '0;
        else        ovf_flag <= ovf_keep | ovf_set_all;
    end

    // Event-type registers, masked to the event field width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTR; i++) evt_type[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_CTR; i++) begin
                if (wr_en && wr_addr == ADDR_W'(A_TYP0 + i) && impl_mask[i])
                    evt_type[i] <= wr_data[EVT_W-1:0];
            end
        end
    end

    // Read multiplexer; absent counters read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data = {16'b0, ctl_n, 4'b0, ctl_long, 5'b0, ctl_en};
            A_EN_SET, A_EN_CLR: rd_data = cnt_en;
            A_IE_SET, A_IE_CLR: rd_data = int_en;
            A_OVF:    rd_data = ovf_flag;
            A_CYC_LO: rd_data = cyc_cnt[31:0];
            A_CYC_HI: rd_data = cyc_cnt[63:32];
            default: begin
                for (int i = 0; i < NUM_CTR; i++) begin
                    if (rd_addr == ADDR_W'(A_CNT0 + i) && impl_mask[i]) rd_data = cnt_val[i];
                    if (rd_addr == ADDR_W'(A_TYP0 + i) && impl_mask[i]) rd_data = 32'(evt_type[i]);
                end
            end
        endcase
    end

    // Interrupt level from enabled, flagged counters.
    assign irq = ctl_en && |(ovf_flag & cnt_en & int_en);

    // R8: flags not cleared by software stay set on the next cycle.
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_flag & $past(ovf_keep)) == $past(ovf_keep)));

    // R9: the cycle clear bit empties the cycle counter.
    p_cclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> (cyc_cnt == 64'd0));

    // R9: the event clear bit empties implemented counter 0.
    p_pclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_clr && impl_mask[0]) |=> (cnt_val[0] == 32'd0));
endmodule

// File: tb/evt_counter_bank_test.sv
`timescale 1ns/10ps
module evt_counter_bank_test;
    localparam int NC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] evt_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic        m_e, m_lc;
    int          m_n;
    logic [31:0] m_en, m_ie, m_ovf;
    logic [31:0] m_ev [NC];
    logic [15:0] m_ty [NC];
    logic [63:0] m_cyc;

    evt_counter_bank #(.NUM_CTR(NC), .NUM_EVT(32), .WIDE_EVT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_in(evt_in), .irq(irq)
    );

    always #2.5 clk = ~clk;

    function automatic bit m_has(int i);
        return (i < NC) && (i < m_n);
    endfunction

    function automatic bit m_act(int i);
        return m_e && m_en[i] && m_has(i);
    endfunction

    function automatic bit m_src(int i, bit sw_ok);
        if (m_ty[i] == 16'd0) return sw_ok && wr_data[i];
        if (m_ty[i] == 16'd30) return 1'b0;
        if (m_ty[i] < 16'd32) return evt_in[m_ty[i][4:0]];
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        if (a == 6'h00) return (32'(m_n) << 11) | (32'(m_lc) << 6) | 32'(m_e);
        if (a == 6'h01 || a == 6'h02) return m_en;
        if (a == 6'h03 || a == 6'h04) return m_ie;
        if (a == 6'h05) return m_ovf;
        if (a == 6'h07) return m_cyc[31:0];
        if (a == 6'h08) return m_cyc[63:32];
        for (int i = 0; i < NC; i++) begin
            if (a == 6'(16 + i) && m_has(i)) return m_ev[i];
            if (a == 6'(32 + i) && m_has(i)) return 32'(m_ty[i]);
        end
        return 32'd0;
    endfunction

    // Model step from the requirements, applied at each rising edge.
    task automatic m_step();
        logic [31:0] nev [NC];
        logic [31:0] sets, imask, w1c;
        logic [63:0] ncyc;
        bit sw_ok, pclr, cclr, ch, wl, wh, il, ih;
        int lo, hi;
        sets = '0; imask = '0;
        for (int i = 0; i < NC; i++) imask[i] = m_has(i);
        imask[31] = 1'b1;
        sw_ok = wr_en && wr_addr == 6'h06 && m_e;
        pclr  = wr_en && wr_addr == 6'h00 && wr_data[1];
        cclr  = wr_en && wr_addr == 6'h00 && wr_data[2];
        for (int p = 0; p < NC / 2; p++) begin
            lo = 2 * p; hi = lo + 1;
            nev[lo] = m_ev[lo]; nev[hi] = m_ev[hi];
            ch = m_ty[hi] == 16'd30 && m_act(hi);
            il = m_act(lo) && m_src(lo, sw_ok);
            wl = il && m_ev[lo] == 32'hFFFF_FFFF;
            ih = m_act(hi) && (ch ? wl : m_src(hi, sw_ok));
            wh = ih && m_ev[hi] == 32'hFFFF_FFFF;
            if (pclr && m_has(lo)) nev[lo] = 0;
            else if (wr_en && wr_addr == 6'(16 + lo) && m_has(lo)) nev[lo] = wr_data;
            else begin
                if (il) nev[lo] = m_ev[lo] + 1;
                if (wl && !ch) sets[lo] = 1'b1;
            end
            if (pclr && m_has(hi)) nev[hi] = 0;
            else if (wr_en && wr_addr == 6'(16 + hi) && m_has(hi)) nev[hi] = wr_data;
            else if (ih) begin
                nev[hi] = m_ev[hi] + 1;
                if (wh) sets[hi] = 1'b1;
            end
        end
        ncyc = m_cyc;
        if (cclr) ncyc = 0;
        else if (wr_en && wr_addr == 6'h07) ncyc = {m_cyc[63:32], wr_data};
        else if (wr_en && wr_addr == 6'h08) ncyc = {wr_data, m_cyc[31:0]};
        else if (m_e && m_en[31]) begin
            ncyc = m_cyc + 1;
            sets[31] = m_lc ? (m_cyc == '1) : (m_cyc[31:0] == '1);
        end
        w1c = (wr_en && wr_addr == 6'h05) ? wr_data : 32'd0;
        m_ovf = (m_ovf & ~w1c) | sets;
        if (wr_en) begin
            if (wr_addr == 6'h00) begin m_e = wr_data[0]; m_lc = wr_data[6]; m_n = int'(wr_data[15:11]); end
            if (wr_addr == 6'h01) m_en = m_en | (wr_data & imask);
            if (wr_addr == 6'h02) m_en = m_en & ~(wr_data & imask);
            if (wr_addr == 6'h03) m_ie = m_ie | (wr_data & imask);
            if (wr_addr == 6'h04) m_ie = m_ie & ~(wr_data & imask);
            for (int i = 0; i < NC; i++)
                if (wr_addr == 6'(32 + i) && imask[i]) m_ty[i] = wr_data[15:0];
        end
        for (int i = 0; i < NC; i++) m_ev[i] = nev[i];
        m_cyc = ncyc;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_e = 0; m_lc = 0; m_n = 0; m_en = 0; m_ie = 0; m_ovf = 0; m_cyc = 0;
            for (int i = 0; i < NC; i++) begin m_ev[i] = 0; m_ty[i] = 0; end
        end else begin
            m_step();
        end
    end

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // R7: interrupt level compared with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk("R7", 64'(irq), 64'(m_e && |(m_ovf & m_en & m_ie)), "irq level");
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic peek(logic [5:0] a, string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, 64'(rd_data), 64'(m_read(a)), $sformatf("model read 0x%0h", a));
    endtask

    task automatic expect_rd(logic [5:0] a, logic [31:0] exp, logic [31:0] mask, string req);
        peek(a, req);
        chk(req, 64'(rd_data & mask), 64'(exp), $sformatf("read 0x%0h", a));
    endtask

    task automatic pulse(logic [31:0] v, int cycles);
        @(negedge clk);
        evt_in = v;
        repeat (cycles) @(negedge clk);
        evt_in = '0;
    endtask

    localparam logic [31:0] ON6 = 32'h1 | (32'd6 << 11);

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 9; a++) expect_rd(6'(a), 32'd0, '1, "R1");
        for (int i = 0; i < NC; i++) expect_rd(6'(16 + i), 32'd0, '1, "R1");
        chk("R1", 64'(irq), 64'd0, "irq after reset");

        // R2 event counting
        wr(6'h00, ON6);
        wr(6'h20, 32'd5); wr(6'h21, 32'd7); wr(6'h22, 32'd0); wr(6'h23, 32'd0); wr(6'h24, 32'd9);
        wr(6'h01, 32'h0000_001F);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            evt_in = ((k % 2 == 1) ? 32'h20 : 32'h0) | ((k % 3 == 0) ? 32'h80 : 32'h0);
        end
        @(negedge clk); evt_in = '0;
        expect_rd(6'h10, 32'd10, '1, "R2");
        expect_rd(6'h11, 32'd7, '1, "R2");
        expect_rd(6'h14, 32'd0, '1, "R2");
        wr(6'h02, 32'h2);
        pulse(32'h80, 3);
        expect_rd(6'h11, 32'd7, '1, "R2");

        // R4 wrap of a plain counter
        wr(6'h10, 32'hFFFF_FFFE);
        pulse(32'h20, 3);
        expect_rd(6'h10, 32'd1, '1, "R4");
        expect_rd(6'h05, 32'h1, '1, "R4");

        // R7 interrupt gating
        wr(6'h03, 32'h1);
        #1 chk("R7", 64'(irq), 64'd1, "irq with flag and enables");
        wr(6'h00, 32'd6 << 11);
        #1 chk("R7", 64'(irq), 64'd0, "irq with global enable off");
        wr(6'h00, ON6);

        // R8 clear flag and interrupt enable
        wr(6'h05, 32'h1);
        expect_rd(6'h05, 32'h0, '1, "R8");
        wr(6'h04, 32'h1);
        expect_rd(6'h03, 32'h0, '1, "R8");
        expect_rd(6'h02, 32'h1D, '1, "R8");

        // R5 software increment
        wr(6'h06, 32'h8000_000F);
        expect_rd(6'h12, 32'd1, '1, "R5");
        expect_rd(6'h13, 32'd1, '1, "R5");
        expect_rd(6'h10, 32'd1, '1, "R5");
        wr(6'h02, 32'h8);
        wr(6'h06, 32'hC);
        expect_rd(6'h12, 32'd2, '1, "R5");
        expect_rd(6'h13, 32'd1, '1, "R5");
        wr(6'h00, 32'd6 << 11);
        wr(6'h06, 32'hF);
        expect_rd(6'h12, 32'd2, '1, "R5");
        wr(6'h00, ON6);
        wr(6'h12, 32'hFFFF_FFFF);
        wr(6'h06, 32'h4);
        expect_rd(6'h12, 32'd0, '1, "R5");
        expect_rd(6'h05, 32'h4, '1, "R4");
        wr(6'h05, 32'h4);

        // R3 chaining
        wr(6'h01, 32'h8);
        wr(6'h23, 32'd30);
        wr(6'h22, 32'd5);
        wr(6'h12, 32'hFFFF_FFFF);
        wr(6'h13, 32'd7);
        pulse(32'h20, 1);
        expect_rd(6'h12, 32'd0, '1, "R3");
        expect_rd(6'h13, 32'd8, '1, "R3");
        expect_rd(6'h05, 32'h0, '1, "R3");
        wr(6'h06, 32'h8);
        expect_rd(6'h13, 32'd8, '1, "R3");
        wr(6'h12, 32'hFFFF_FFFF);
        wr(6'h13, 32'hFFFF_FFFF);
        pulse(32'h20, 1);
        expect_rd(6'h13, 32'd0, '1, "R3");
        expect_rd(6'h05, 32'h8, '1, "R3");
        wr(6'h05, 32'h8);

        // R12 transitions keep values
        wr(6'h12, 32'h1234);
        wr(6'h13, 32'h55);
        wr(6'h02, 32'h8);
        expect_rd(6'h12, 32'h1234, '1, "R12");
        expect_rd(6'h13, 32'h55, '1, "R12");
        wr(6'h01, 32'h8);
        expect_rd(6'h12, 32'h1234, '1, "R12");
        expect_rd(6'h05, 32'h0, '1, "R12");
        wr(6'h02, 32'h8);
        wr(6'h12, 32'hFFFF_FFFF);
        pulse(32'h20, 1);
        expect_rd(6'h05, 32'h4, '1, "R3");
        expect_rd(6'h13, 32'h55, '1, "R3");
        wr(6'h05, 32'hFFFF_FFFF);

        // R6 cycle counter, short and long overflow
        wr(6'h07, 32'hFFFF_FFF0);
        wr(6'h01, 32'h8000_0000);
        repeat (20) @(negedge clk);
        expect_rd(6'h05, 32'h8000_0000, 32'h8000_0000, "R6");
        expect_rd(6'h08, 32'd1, '1, "R6");
        wr(6'h02, 32'h8000_0000);
        wr(6'h05, 32'hFFFF_FFFF);
        wr(6'h00, ON6 | 32'h40);
        wr(6'h08, 32'd0);
        wr(6'h07, 32'hFFFF_FFF8);
        wr(6'h01, 32'h8000_0000);
        repeat (20) @(negedge clk);
        expect_rd(6'h05, 32'h0, 32'h8000_0000, "R6");
        expect_rd(6'h08, 32'd1, '1, "R6");
        wr(6'h02, 32'h8000_0000);
        wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h07, 32'hFFFF_FFF8);
        wr(6'h01, 32'h8000_0000);
        repeat (20) @(negedge clk);
        expect_rd(6'h05, 32'h8000_0000, 32'h8000_0000, "R6");
        expect_rd(6'h08, 32'd0, '1, "R6");

        // R9 clear bits
        wr(6'h02, 32'h8000_0000);
        wr(6'h00, ON6 | 32'h4);
        expect_rd(6'h07, 32'd0, '1, "R9");
        expect_rd(6'h08, 32'd0, '1, "R9");
        wr(6'h07, 32'h77);
        wr(6'h00, ON6 | 32'h2);
        for (int i = 0; i < NC; i++) expect_rd(6'(16 + i), 32'd0, '1, "R9");
        expect_rd(6'h07, 32'h77, '1, "R9");

        // R10 implemented range
        wr(6'h14, 32'h99);
        wr(6'h00, 32'h1 | (32'd2 << 11));
        expect_rd(6'h14, 32'd0, '1, "R10");
        expect_rd(6'h24, 32'd0, '1, "R10");
        wr(6'h13, 32'd5);
        wr(6'h01, 32'h20);
        expect_rd(6'h01, 32'h0, 32'h20, "R10");
        wr(6'h00, ON6);
        expect_rd(6'h14, 32'h99, '1, "R10");
        expect_rd(6'h13, 32'd0, '1, "R10");
        wr(6'h00, 32'h1);
        wr(6'h01, 32'h8000_0000);
        expect_rd(6'h01, 32'h8000_0000, 32'h8000_0000, "R10");
        expect_rd(6'h10, 32'd0, '1, "R10");
        wr(6'h02, 32'h8000_0000);

        // R11 event field width
        wr(6'h00, ON6);
        wr(6'h20, 32'hFFFF_FFFF);
        expect_rd(6'h20, 32'h0000_FFFF, '1, "R11");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule